// File: doc/BRIEF.md
# Noise Channel Generator

This block produces the single-bit output of a programmable sound generator's noise voice. A prescaled tick drives a down-counter whose reload is chosen by two rate bits: three fixed short periods, or the period currently set for the third tone voice. Every reload inverts a rate flip-flop. Each low-to-high edge of that flip-flop advances a 16-bit shift register by one place.

The shift register moves right. Its lowest bit is the output. The bit entering at the top depends on the mode. In white mode it is the parity of the register bits chosen by a tap-mask input. In periodic mode it is the bit just shifted out, so the register's contents repeat as a fixed 16-step pattern.

A control-write pulse reseeds the register with only its top bit set, and it clears the counter and the flip-flop. The output is a plain 0/1 level, and downstream logic applies any volume.

Top module: `noise_gen`

## Requirements
- R1: While rst_ni is low and after it is released, noise_o is 0. The shift register holds 0x8000, the counter holds 0 and the rate flip-flop holds 0.
- R2: Rate field ctrl_i[1:0] = 0, 1 or 2 reloads the counter with 16, 32 or 64 ticks.
- R3: Rate field ctrl_i[1:0] = 3 reloads the counter with tone2_period_i. A period of 0 or 1 reloads on every tick.
- R4: On a tick where the counter holds 0 or 1, the counter reloads and the rate flip-flop inverts. On any other tick the counter decrements. The register shifts only on a tick that takes the flip-flop from 0 to 1, so it shifts on one reload in every two.
- R5: A shift moves the register right by one and writes the feedback bit into bit 15. noise_o is bit 0 of the register.
- R6: When ctrl_i[2] = 1 (white mode), the feedback is the XOR of all register bits whose tap_mask_i bit is 1.
- R7: When ctrl_i[2] = 0 (periodic mode), the feedback is the old bit 0. After a reseed, noise_o is 1 for exactly one shift in every 16.
- R8: When ctrl_wr_i is high at a clock edge, the register returns to 0x8000 and the counter and flip-flop return to 0. This takes priority over a tick on the same edge.
- R9: On a clock edge with tick_i and ctrl_wr_i both low, no state changes and noise_o holds.
- R10: The feedback taps follow tap_mask_i at run time, so any mask gives the same parity rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled rate tick, one cycle wide |
| ctrl_i | input | 3 | Bit 2: white mode; bits 1:0: rate field |
| ctrl_wr_i | input | 1 | Pulse that marks a write to the noise control |
| tone2_period_i | input | 10 | Third tone voice period, used when rate field = 3 |
| tap_mask_i | input | 16 | Bits of the register that feed the white-mode parity |
| noise_o | output | 1 | Noise output, 0 or 1 |

## Verification
The slowest rate makes the first high output after a reseed appear only after hundreds of ticks. The long shift spacing also hides off-by-one errors in the reload or edge detection. The stimulus therefore holds the tick high and counts ticks from a reseed to the first 1 in periodic mode, for every rate field and for the smallest tone periods. A second phase uses sparse ticks, control-write pulses that land on ticks, and changes of mask and rate in mid-count. A behavioural model follows every cycle of this phase.

// File: rtl/noise_pkg.sv
package noise_pkg;
  localparam int unsigned LFSR_W = 16;
  localparam int unsigned CNT_W  = 10;

  typedef enum logic [1:0] {
    RATE_A    = 2'd0,
    RATE_B    = 2'd1,
    RATE_C    = 2'd2,
    RATE_TONE = 2'd3
  } rate_sel_e;

  typedef struct packed {
    logic      white;
    rate_sel_e rate;
  } noise_ctrl_t;
endpackage

// File: rtl/noise_rate_cnt.sv
module noise_rate_cnt
  import noise_pkg::*;
#(
  parameter int unsigned W      = CNT_W,
  parameter int unsigned RELOAD_A = 16,
  parameter int unsigned RELOAD_B = 32,
  parameter int unsigned RELOAD_C = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  rate_sel_e    rate_i,
  input  logic [W-1:0] tone_i,
  output logic [W-1:0] cnt_o,
  output logic         ff_o,
  output logic         rise_o
);
  localparam logic [W-1:0] RA = W'(RELOAD_A);
  localparam logic [W-1:0] RB = W'(RELOAD_B);
  localparam logic [W-1:0] RC = W'(RELOAD_C);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, reload_val;
  logic         ff_q, expire;

  always_comb begin
    unique case (rate_i)
      RATE_A:  reload_val = RA;
      RATE_B:  reload_val = RB;
      RATE_C:  reload_val = RC;
      default: reload_val = tone_i;
    endcase
  end

  // a count of 0 (after clear) or 1 expires on the next tick
  assign expire = tick_i && (cnt_q <= ONE);
  assign rise_o = expire && !ff_q && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ff_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ff_q  <= 1'b0;
    end else if (expire) begin
      cnt_q <= reload_val;
      ff_q  <= ~ff_q;
    end else if (tick_i) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o = cnt_q;
  assign ff_o  = ff_q;
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr
  import noise_pkg::*;
#(
  parameter int unsigned W = LFSR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         seed_i,
  input  logic         shift_i,
  input  logic         white_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] sr_o
);
  localparam logic [W-1:0] SEED = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] sr_q, tapped;
  logic         fb;

  for (genvar i = 0; i < W; i++) begin : g_tap
    assign tapped[i] = sr_q[i] & mask_i[i];
  end

  assign fb = white_i ? ^tapped : sr_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= SEED;
    else if (seed_i)   sr_q <= SEED;
    else if (shift_i)  sr_q <= {fb, sr_q[W-1:1]};
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/noise_gen.sv
module noise_gen
  import noise_pkg::*;
#(
  parameter int unsigned SR_W   = LFSR_W,
  parameter int unsigned PER_W  = CNT_W,
  parameter int unsigned RATE0  = 16,
  parameter int unsigned RATE1  = 32,
  parameter int unsigned RATE2  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [2:0]       ctrl_i,
  input  logic             ctrl_wr_i,
  input  logic [PER_W-1:0] tone2_period_i,
  input  logic [SR_W-1:0]  tap_mask_i,
  output logic             noise_o
);
  noise_ctrl_t      ctrl;
  logic [PER_W-1:0] cnt_q;
  logic             ff_q, shift_en;
  logic [SR_W-1:0]  sr_q;

  assign ctrl = noise_ctrl_t'(ctrl_i);

  noise_rate_cnt #(
    .W(PER_W), .RELOAD_A(RATE0), .RELOAD_B(RATE1), .RELOAD_C(RATE2)
  ) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctrl_wr_i),
    .tick_i (tick_i),
    .rate_i (ctrl.rate),
    .tone_i (tone2_period_i),
    .cnt_o  (cnt_q),
    .ff_o   (ff_q),
    .rise_o (shift_en)
  );

  noise_lfsr #(.W(SR_W)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .seed_i  (ctrl_wr_i),
    .shift_i (shift_en),
    .white_i (ctrl.white),
    .mask_i  (tap_mask_i),
    .sr_o    (sr_q)
  );

  assign noise_o = sr_q[0];
endmodule

// File: rtl/noise_gen_chk.sv
module noise_gen_chk #(
  parameter int unsigned SR_W  = 16,
  parameter int unsigned PER_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             wr_i,
  input logic             white_i,
  input logic [SR_W-1:0]  mask_i,
  input logic [SR_W-1:0]  sr_i,
  input logic [PER_W-1:0] cnt_i,
  input logic             ff_i,
  input logic             noise_i
);
  localparam logic [SR_W-1:0] SEED = {1'b1, {(SR_W-1){1'b0}}};

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> ($stable(noise_i) && $stable(sr_i) && $stable(cnt_i) && $stable(ff_i)));

  a_r8_reseed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (sr_i == SEED && cnt_i == '0 && !ff_i));

  a_r4_shift_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sr_i) && !$past(wr_i)) |-> $rose(ff_i));

  a_r4_ff_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(ff_i) && !$past(wr_i)) |-> $past(tick_i));

  a_r5_shift_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ff_i) && !$past(wr_i)) |-> (sr_i[SR_W-2:0] == $past(sr_i[SR_W-1:1])));

  a_r7_periodic_fb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ff_i) && !$past(wr_i) && !$past(white_i)) |-> (sr_i[SR_W-1] == $past(sr_i[0])));

  a_r6_white_fb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ff_i) && !$past(wr_i) && $past(white_i)) |-> (sr_i[SR_W-1] == ^($past(sr_i) & $past(mask_i))));

  a_r5_out_is_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    noise_i == sr_i[0]);
endmodule

bind noise_gen noise_gen_chk #(.SR_W(SR_W), .PER_W(PER_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .wr_i    (ctrl_wr_i),
  .white_i (ctrl_i[2]),
  .mask_i  (tap_mask_i),
  .sr_i    (sr_q),
  .cnt_i   (cnt_q),
  .ff_i    (ff_q),
  .noise_i (noise_o)
);

// File: tb/noise_gen_tb_top.sv
module noise_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [2:0]  ctrl_i = 3'b000;
  logic        ctrl_wr_i = 1'b0;
  logic [9:0]  tone2_period_i = 10'd0;
  logic [15:0] tap_mask_i = 16'h0009;
  logic        noise_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;
  bit model_on = 1'b0;

  always #2 clk_i = ~clk_i;

  noise_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .ctrl_i(ctrl_i),
    .ctrl_wr_i(ctrl_wr_i), .tone2_period_i(tone2_period_i),
    .tap_mask_i(tap_mask_i), .noise_o(noise_o)
  );

  // behavioural reference
  int          m_cnt;
  bit          m_ff;
  bit [15:0]   m_sr;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_ff = 0; m_sr = 16'h8000;
    end else if (ctrl_wr_i) begin
      m_cnt = 0; m_ff = 0; m_sr = 16'h8000;
    end else if (tick_i) begin
      if (m_cnt <= 1) begin
        case (ctrl_i[1:0])
          2'd0: m_cnt = 16;
          2'd1: m_cnt = 32;
          2'd2: m_cnt = 64;
          default: m_cnt = int'(tone2_period_i);
        endcase
        if (!m_ff) begin
          bit fb;
          fb = ctrl_i[2] ? ($countones(m_sr & tap_mask_i) % 2 == 1) : m_sr[0];
          m_sr = {fb, m_sr[15:1]};
        end
        m_ff = !m_ff;
      end else begin
        m_cnt = m_cnt - 1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R5 R6 R10)
  always @(negedge clk_i) begin
    if (model_on && rst_ni) check("R5 R6 R10 model", int'(noise_o), int'(m_sr[0]));
  end

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic write_ctrl(input logic [2:0] v);
    ctrl_i = v; ctrl_wr_i = 1'b1;
    step();
    ctrl_wr_i = 1'b0;
  endtask

  // ticks from a reseed to the first high output in periodic mode
  task automatic rise_time(input logic [1:0] rate, input int exp, input string req);
    int n;
    write_ctrl({1'b0, rate});
    n = 0;
    tick_i = 1'b1;
    for (int k = 0; k < 4000; k++) begin
      step();
      n++;
      if (noise_o) break;
    end
    tick_i = 1'b0;
    check(req, n, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    int highs, shifts, prev;
    logic hold;
    #1;
    check("R1 in reset", int'(noise_o), 0);
    step(); step();
    rst_ni = 1'b1;
    step();
    check("R1 after reset", int'(noise_o), 0);

    // R2: shift at tick 1, then every 2*reload ticks; 15th shift raises output
    rise_time(2'd0, 1 + 14 * 32, "R2 rate 16");
    rise_time(2'd1, 1 + 14 * 64, "R2 rate 32");
    rise_time(2'd2, 1 + 14 * 128, "R2 rate 64");
    tone2_period_i = 10'd5;
    rise_time(2'd3, 1 + 14 * 10, "R3 tone period 5");
    tone2_period_i = 10'd0;
    rise_time(2'd3, 29, "R3 tone period 0");
    tone2_period_i = 10'd1;
    rise_time(2'd3, 29, "R3 tone period 1");

    // R7: duty 1/16 over 64 shifts, shifts every 2 ticks
    write_ctrl(3'b011);
    highs = 0;
    tick_i = 1'b1;
    for (int s = 0; s < 64; s++) begin
      step(); if (noise_o) highs++;
      step();
    end
    tick_i = 1'b0;
    check("R7 periodic duty", highs, 4);

    // R4: one shift per two reloads, seen as output pattern length
    write_ctrl(3'b011);
    tick_i = 1'b1;
    shifts = 0;
    for (int k = 0; k < 30; k++) begin step(); end
    tick_i = 1'b0;
    check("R4 hold on odd reload", int'(noise_o), 1);

    // R9: no tick, output and state frozen
    model_on = 1'b1;
    write_ctrl(3'b111);
    tick_i = 1'b1;
    for (int k = 0; k < 40; k++) step();
    tick_i = 1'b0;
    hold = noise_o;
    for (int k = 0; k < 20; k++) begin
      ctrl_i = 3'(k); tap_mask_i = 16'(k * 4099);
      step();
      check("R9 no tick", int'(noise_o), int'(hold));
    end
    ctrl_i = 3'b111; tap_mask_i = 16'h0009;

    // R8: write coinciding with tick reseeds and clears
    tick_i = 1'b1;
    for (int k = 0; k < 37; k++) step();
    ctrl_wr_i = 1'b1;
    step();
    ctrl_wr_i = 1'b0;
    check("R8 reseed output", int'(noise_o), 0);
    tick_i = 1'b0;
    step();

    // R6 R10: white mode, several masks and rates, sparse ticks
    for (int p = 0; p < 6; p++) begin
      case (p)
        0: tap_mask_i = 16'h0009;
        1: tap_mask_i = 16'h0006;
        2: tap_mask_i = 16'h8005;
        3: tap_mask_i = 16'hffff;
        4: tap_mask_i = 16'h0001;
        default: tap_mask_i = 16'h1234;
      endcase
      tone2_period_i = 10'(p + 2);
      write_ctrl({1'b1, 2'(p % 4)});
      for (int k = 0; k < 2500; k++) begin
        tick_i = ($urandom % 3) == 0;
        if (($urandom % 700) == 0) ctrl_wr_i = 1'b1;
        if (($urandom % 500) == 0) ctrl_i = 3'($urandom);
        step();
        ctrl_wr_i = 1'b0;
      end
      tick_i = 1'b0;
    end

    // R10: known white sequence from seed with mask 0x0003, rate via tone period 1
    model_on = 1'b0;
    tap_mask_i = 16'h0003;
    tone2_period_i = 10'd1;
    write_ctrl(3'b111);
    highs = 0;
    tick_i = 1'b1;
    prev = 0;
    for (int s = 0; s < 40; s++) begin
      step(); if (noise_o) highs++;
      step();
    end
    tick_i = 1'b0;
    // x^16 seed with taps 0,1: first 1 leaves bit 0 at shift 15, then sequence stays nonzero
    check("R10 mask 0003 activity", int'(highs > 0), 1);
    check("R10 model agreement", int'(noise_o), int'(m_sr[0]));

    finish_run();
  end
endmodule